// File: doc/BRIEF.md
# Per-Access Policy Set-Associative Data Cache

A set-associative data cache between a single-word core request port and a slower memory port that moves one whole line per transfer. The set is chosen by the index bits of the address. Each way's stored tag is then compared, and a way counts as a hit only when its valid bit is also set. Every core request carries its own attributes: cacheable or not, write-through or write-back, and allocate-on-write-miss or not. The cache applies these attributes to that request alone.

Besides loads and stores, the core can send by-address maintenance operations. Invalidate drops a line. Clean writes a dirty line back to memory. Zero clears the data of a resident line. Replacement uses a round-robin pointer kept for each set. A dirty victim is written back before the refill read is issued. The geometry is set by parameters. The defaults are 4 ways, 256 sets and 64-byte lines, so the index is address bits [13:6].

Top module: `wcache_top`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` and `mem_req_o` are 0, and every line is invalid, so the first access to any address misses.
- R2: The set index is address bits [OFF_W+IDX_W-1:OFF_W]. Addresses that differ by a multiple of SETS*LINE_BYTES (0x4000 by default) share a set and compete for its ways.
- R3: A request hits only when a way of the selected set holds a matching tag with its valid bit set. `rsp_hit_o` is 1 only for a request served without a refill.
- R4: A cacheable load miss issues one line read (`mem_we_o`=0), installs the line, then answers with the addressed word and `rsp_hit_o`=0. A repeat load hits with no memory traffic.
- R5: A cacheable store miss with `req_walloc_i`=0 issues exactly one memory write. That write carries the word at its line offset, and `mem_be_o` has only the request's byte-enables set. The cache is unchanged, so a later load of that address misses.
- R6: A cacheable store miss with `req_walloc_i`=1 first refills the line, as a load miss does, then merges the write data under the byte-enables.
- R7: A store hit with `req_wt_i`=1 updates the cached word and issues one memory word write. It leaves the line's dirty state unchanged.
- R8: A store hit with `req_wt_i`=0 makes no memory access and marks the line dirty. A dirty victim is written back as one full-line write (all `mem_be_o` bits set) before the refill read.
- R9: Each set's victim pointer starts at way 0 and advances by one, wrapping, on every refill of that set.
- R10: With `req_cacheable_i`=0, a load reads memory and returns the word with `rsp_hit_o`=0, and a store writes memory. Neither looks up nor allocates a line.
- R11: Invalidate (`req_op_i`=2) on a resident line clears its valid and dirty bits. Dirty data is discarded without a memory write.
- R12: Clean (`req_op_i`=3) on a resident dirty line issues one full-line write and clears the dirty bit. On a clean or absent line it causes no memory traffic.
- R13: Zero (`req_op_i`=4) on a resident line sets all its data to 0 and marks it dirty. On an absent line it has no effect. Loads use `req_op_i`=0 and stores use 1.
- R14: A request is accepted only when `req_ready_o` is 1, which holds only while idle. Each accepted request gives exactly one single-cycle `rsp_valid_o` pulse. For maintenance operations, `rsp_hit_o` reports residency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_op_i | input | 3 | 0 load, 1 store, 2 invalidate, 3 clean, 4 zero |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Store data |
| req_be_i | input | 4 | Store byte-enables |
| req_cacheable_i | input | 1 | Access may use the cache |
| req_wt_i | input | 1 | 1 write-through, 0 write-back |
| req_walloc_i | input | 1 | Allocate on store miss |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Load data |
| rsp_hit_o | output | 1 | Served without refill / line resident |
| mem_req_o | output | 1 | Memory transfer request, held until ready |
| mem_we_o | output | 1 | Transfer is a write |
| mem_addr_o | output | ADDR_W | Line-aligned address |
| mem_wdata_o | output | LINE_BYTES*8 | Write line |
| mem_be_o | output | LINE_BYTES | Byte mask of the write |
| mem_ready_i | input | 1 | Transfer completes this cycle |
| mem_rdata_i | input | LINE_BYTES*8 | Read line, valid with ready |

## Verification
The bench fills one set beyond its way count, so a write-back line becomes the victim. A design that refilled before the write-back, or chose the wrong way, would return stale data or show the wrong transfer counts. It reads a dirty line through the non-cacheable path, which must see stale memory, and then reads it again after a clean, which must see the merged data. A bypass that wrongly used the cache, or a clean that never wrote, is caught there. Invalidating a dirty line must lose its data, and zeroing an absent line must leave memory untouched. A final comparison of the whole memory image against the model catches any write that lands at the wrong address, under the wrong byte mask, or not at all.

// File: rtl/wcache_pkg.sv
package wcache_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_INVAL = 3'd2,
    OP_CLEAN = 3'd3,
    OP_ZERO  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_WB,
    S_FILL,
    S_WORD_WR,
    S_UNC_RD
  } state_e;
endpackage

// File: rtl/wcache_tags.sv
module wcache_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 18,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [TAG_W-1:0]                 tag_i,
  output logic                             hit_o,
  output logic [WAY_W-1:0]                 hit_way_o,
  output logic [WAYS-1:0]                  way_valid_o,
  output logic [WAYS-1:0]                  way_dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]       way_tag_o,
  input  logic                             upd_i,
  input  logic [WAY_W-1:0]                 upd_way_i,
  input  logic                             upd_valid_i,
  input  logic                             upd_dirty_i,
  input  logic [TAG_W-1:0]                 upd_tag_i
);
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (upd_i) begin
      valid_q[idx_i][upd_way_i] <= upd_valid_i;
      dirty_q[idx_i][upd_way_i] <= upd_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (upd_i) tag_q[idx_i][upd_way_i] <= upd_tag_i;
  end

  assign way_valid_o = valid_q[idx_i];
  assign way_dirty_o = dirty_q[idx_i];
  assign way_tag_o   = tag_q[idx_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    end
  end
  assign hit_o = |hit_vec;

  // R3: a tag is never resident in two ways of one set
  a_r3_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/wcache_data.sv
module wcache_data #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int WORDS = 16,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic                        clk_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [WAY_W-1:0]            rd_way_i,
  output logic [WORDS-1:0][31:0]      rd_line_o,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic                        line_we_i,
  input  logic [WORDS-1:0][31:0]      line_i,
  input  logic                        word_we_i,
  input  logic [WSEL_W-1:0]           word_sel_i,
  input  logic [3:0]                  word_be_i,
  input  logic [31:0]                 word_i
);
  logic [WORDS-1:0][31:0] line_q [SETS][WAYS];

  always_ff @(posedge clk_i) begin
    if (line_we_i) begin
      line_q[idx_i][wr_way_i] <= line_i;
    end else if (word_we_i) begin
      for (int b = 0; b < 4; b++) begin
        if (word_be_i[b]) line_q[idx_i][wr_way_i][word_sel_i][8*b +: 8] <= word_i[8*b +: 8];
      end
    end
  end

  assign rd_line_o = line_q[idx_i][rd_way_i];
endmodule

// File: rtl/wcache_rr.sv
module wcache_rr #(
  parameter int WAYS = 4,
  parameter int SETS = 256,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             adv_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAY_W-1:0] ptr_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
    end else if (adv_i) begin
      ptr_q[idx_i] <= ptr_q[idx_i] + WAY_W'(1);
    end
  end

  assign victim_o = ptr_q[idx_i];

  a_r9_rr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (ptr_q[$past(idx_i)] == WAY_W'($past(victim_o) + WAY_W'(1))));
endmodule

// File: rtl/wcache_top.sv
module wcache_top
  import wcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 256,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W = LINE_BYTES * 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [2:0]            req_op_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [31:0]           req_wdata_i,
  input  logic [3:0]            req_be_i,
  input  logic                  req_cacheable_i,
  input  logic                  req_wt_i,
  input  logic                  req_walloc_i,
  output logic                  rsp_valid_o,
  output logic [31:0]           rsp_rdata_o,
  output logic                  rsp_hit_o,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [LINE_W-1:0]     mem_wdata_o,
  output logic [LINE_BYTES-1:0] mem_be_o,
  input  logic                  mem_ready_i,
  input  logic [LINE_W-1:0]     mem_rdata_i
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int WAY_W  = $clog2(WAYS);

  state_e              state_q, state_d;
  op_e                 op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [31:0]         wdata_q;
  logic [3:0]          be_q;
  logic                cach_q, wt_q, walloc_q;
  logic                missed_q, missed_d;
  logic [WAY_W-1:0]    way_q, way_d;
  logic                rsp_valid_q, rsp_hit_q;
  logic [31:0]         rsp_rdata_q;

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [WSEL_W-1:0]   wsel;
  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[2 +: WSEL_W];

  logic                       hit;
  logic [WAY_W-1:0]           hit_way, victim;
  logic [WAYS-1:0]            way_valid, way_dirty;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic                       tg_upd, tg_valid, tg_dirty;
  logic [WAY_W-1:0]           tg_way;
  logic [TAG_W-1:0]           tg_tag;

  logic [WORDS-1:0][31:0]     rd_line, dat_line, mem_line;
  logic [WAY_W-1:0]           rd_way, dat_way;
  logic                       dat_line_we, dat_word_we;
  logic                       rr_adv, rsp_set, rsp_hit_d, miss_go;
  logic [31:0]                rsp_data_d;

  assign mem_line = mem_rdata_i;
  assign rd_way   = (state_q == S_WB) ? way_q : hit_way;

  wcache_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .hit_o(hit), .hit_way_o(hit_way),
    .way_valid_o(way_valid), .way_dirty_o(way_dirty), .way_tag_o(way_tag),
    .upd_i(tg_upd), .upd_way_i(tg_way), .upd_valid_i(tg_valid),
    .upd_dirty_i(tg_dirty), .upd_tag_i(tg_tag)
  );

  wcache_data #(.WAYS(WAYS), .SETS(SETS), .WORDS(WORDS)) u_data (
    .clk_i,
    .idx_i(idx), .rd_way_i(rd_way), .rd_line_o(rd_line),
    .wr_way_i(dat_way), .line_we_i(dat_line_we), .line_i(dat_line),
    .word_we_i(dat_word_we), .word_sel_i(wsel), .word_be_i(be_q), .word_i(wdata_q)
  );

  wcache_rr #(.WAYS(WAYS), .SETS(SETS)) u_rr (
    .clk_i, .rst_ni, .idx_i(idx), .adv_i(rr_adv), .victim_o(victim)
  );

  always_comb begin
    state_d     = state_q;
    way_d       = way_q;
    missed_d    = missed_q;
    tg_upd      = 1'b0;
    tg_way      = hit_way;
    tg_valid    = 1'b1;
    tg_dirty    = 1'b0;
    tg_tag      = tag;
    dat_line_we = 1'b0;
    dat_word_we = 1'b0;
    dat_way     = hit_way;
    dat_line    = mem_line;
    rr_adv      = 1'b0;
    rsp_set     = 1'b0;
    rsp_data_d  = '0;
    rsp_hit_d   = 1'b0;
    miss_go     = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        missed_d = 1'b0;
        if (req_valid_i) state_d = S_LOOKUP;
      end
      S_LOOKUP: begin
        if (!cach_q && op_q == OP_LOAD) begin
          state_d = S_UNC_RD;
        end else if (!cach_q && op_q == OP_STORE) begin
          state_d = S_WORD_WR;
        end else begin
          unique case (op_q)
            OP_LOAD: begin
              if (hit) begin
                rsp_set    = 1'b1;
                rsp_data_d = rd_line[wsel];
                rsp_hit_d  = !missed_q;
              end else begin
                miss_go = 1'b1;
              end
            end
            OP_STORE: begin
              if (hit) begin
                dat_word_we = 1'b1;
                tg_upd      = 1'b1;
                tg_dirty    = wt_q ? way_dirty[hit_way] : 1'b1;
                if (wt_q) begin
                  state_d = S_WORD_WR;
                end else begin
                  rsp_set   = 1'b1;
                  rsp_hit_d = !missed_q;
                end
              end else if (walloc_q) begin
                miss_go = 1'b1;
              end else begin
                state_d = S_WORD_WR;
              end
            end
            OP_INVAL: begin
              tg_upd    = hit;
              tg_valid  = 1'b0;
              tg_tag    = way_tag[hit_way];
              rsp_set   = 1'b1;
              rsp_hit_d = hit;
            end
            OP_CLEAN: begin
              if (hit && way_dirty[hit_way]) begin
                way_d   = hit_way;
                state_d = S_WB;
              end else begin
                rsp_set   = 1'b1;
                rsp_hit_d = hit;
              end
            end
            OP_ZERO: begin
              dat_line_we = hit;
              dat_line    = '0;
              tg_upd      = hit;
              tg_dirty    = 1'b1;
              rsp_set     = 1'b1;
              rsp_hit_d   = hit;
            end
            default: rsp_set = 1'b1;
          endcase
        end
        if (miss_go) begin
          way_d    = victim;
          missed_d = 1'b1;
          state_d  = (way_valid[victim] && way_dirty[victim]) ? S_WB : S_FILL;
        end
      end
      S_WB: begin
        if (mem_ready_i) begin
          if (op_q == OP_CLEAN) begin
            tg_upd    = 1'b1;
            tg_way    = way_q;
            tg_tag    = way_tag[way_q];
            rsp_set   = 1'b1;
            rsp_hit_d = 1'b1;
          end else begin
            state_d = S_FILL;
          end
        end
      end
      S_FILL: begin
        if (mem_ready_i) begin
          dat_line_we = 1'b1;
          dat_way     = way_q;
          tg_upd      = 1'b1;
          tg_way      = way_q;
          rr_adv      = 1'b1;
          state_d     = S_LOOKUP;
        end
      end
      S_WORD_WR: begin
        if (mem_ready_i) begin
          rsp_set   = 1'b1;
          rsp_hit_d = hit && cach_q && !missed_q;
        end
      end
      S_UNC_RD: begin
        if (mem_ready_i) begin
          rsp_set    = 1'b1;
          rsp_data_d = mem_line[wsel];
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (rsp_set) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_LOAD;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      cach_q      <= 1'b0;
      wt_q        <= 1'b0;
      walloc_q    <= 1'b0;
      missed_q    <= 1'b0;
      way_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_hit_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      missed_q    <= missed_d;
      way_q       <= way_d;
      rsp_valid_q <= rsp_set;
      if (rsp_set) begin
        rsp_rdata_q <= rsp_data_d;
        rsp_hit_q   <= rsp_hit_d;
      end
      if (state_q == S_IDLE && req_valid_i) begin
        op_q     <= op_e'(req_op_i);
        addr_q   <= req_addr_i;
        wdata_q  <= req_wdata_i;
        be_q     <= req_be_i;
        cach_q   <= req_cacheable_i;
        wt_q     <= req_wt_i;
        walloc_q <= req_walloc_i;
      end
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_hit_o   = rsp_hit_q;

  assign mem_req_o  = (state_q == S_WB) || (state_q == S_FILL) ||
                      (state_q == S_WORD_WR) || (state_q == S_UNC_RD);
  assign mem_we_o   = (state_q == S_WB) || (state_q == S_WORD_WR);
  assign mem_addr_o = (state_q == S_WB) ? {way_tag[way_q], idx, {OFF_W{1'b0}}}
                                        : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = (state_q == S_WB) ? rd_line : {WORDS{wdata_q}};
  assign mem_be_o    = (state_q == S_WB) ? {LINE_BYTES{1'b1}} :
                       (state_q == S_WORD_WR) ? (LINE_BYTES'(be_q) << {wsel, 2'b00}) : '0;

  a_r14_accept_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r14_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r8_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/wcache_top_tb_top.sv
`timescale 1ns/1ps
module wcache_top_tb_top;
  localparam int ADDR_W = 16, WAYS = 4, SETS = 4, LB = 16;
  localparam int WORDS = LB / 4, MEMW = 1 << (ADDR_W - 2);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [2:0] req_op = 0;
  logic [ADDR_W-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0] req_be = 0;
  logic req_c = 0, req_wt = 0, req_wa = 0;
  logic rsp_valid, rsp_hit;
  logic [31:0] rsp_rdata;
  logic mem_req, mem_we, mem_ready = 0;
  logic [ADDR_W-1:0] mem_addr;
  logic [LB*8-1:0] mem_wdata, mem_rdata = '0;
  logic [LB-1:0] mem_be;

  wcache_top #(.ADDR_W(ADDR_W), .WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .req_cacheable_i(req_c), .req_wt_i(req_wt), .req_walloc_i(req_wa),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_hit_o(rsp_hit),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, dev_rd = 0, dev_wr = 0;
  logic [31:0] dev_mem [MEMW];
  logic [31:0] ref_mem [MEMW];
  bit busy = 0;

  // reference cache state
  bit m_valid [SETS][WAYS];
  bit m_dirty [SETS][WAYS];
  int m_tag   [SETS][WAYS];
  logic [31:0] m_data [SETS][WAYS][WORDS];
  int m_rr [SETS];
  logic [31:0] e_rdata;
  bit e_hit;
  int e_rd, e_wr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: ready after three cycles of request
  int lat = 0;
  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (mem_req && !mem_ready) begin
      if (lat == 2) begin
        lat = 0;
        mem_ready <= 1'b1;
        if (mem_we) begin
          for (int k = 0; k < WORDS; k++)
            for (int b = 0; b < 4; b++)
              if (mem_be[4*k+b]) dev_mem[(mem_addr >> 2) + k][8*b +: 8] <= mem_wdata[32*k + 8*b +: 8];
          dev_wr++;
        end else begin
          for (int k = 0; k < WORDS; k++) mem_rdata[32*k +: 32] <= dev_mem[(mem_addr >> 2) + k];
          dev_rd++;
        end
      end else lat++;
    end
  end

  // R14: no response without an outstanding request, checked every clock
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !busy) chk(1'b0, "R14 spurious response", 32'd1, 32'd0);
  end

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) o[8*b +: 8] = d[8*b +: 8];
    return o;
  endfunction

  task automatic m_wb(input int s, input int w);
    int base = ((m_tag[s][w] << 6) | (s << 4)) >> 2;
    for (int k = 0; k < WORDS; k++) ref_mem[base + k] = m_data[s][w][k];
    e_wr++;
  endtask

  task automatic m_fill(input int s, input int t, output int w);
    w = m_rr[s];
    if (m_valid[s][w] && m_dirty[s][w]) m_wb(s, w);
    for (int k = 0; k < WORDS; k++) m_data[s][w][k] = ref_mem[((t << 6) | (s << 4)) / 4 + k];
    m_valid[s][w] = 1; m_dirty[s][w] = 0; m_tag[s][w] = t;
    e_rd++;
    m_rr[s] = (m_rr[s] + 1) % WAYS;
  endtask

  task automatic model(input int op, input int a, input logic [31:0] d, input logic [3:0] be,
                       input bit c, input bit wt, input bit wa);
    int s = (a >> 4) % SETS, t = a >> 6, wi = (a >> 2) % WORDS, hw = -1;
    e_rd = 0; e_wr = 0; e_hit = 0; e_rdata = 0;
    for (int w = 0; w < WAYS; w++) if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
    if (!c && op < 2) begin
      if (op == 0) begin e_rdata = ref_mem[a >> 2]; e_rd = 1; end
      else begin ref_mem[a >> 2] = merge(ref_mem[a >> 2], d, be); e_wr = 1; end
      return;
    end
    e_hit = (hw >= 0);
    case (op)
      0: begin
        if (hw < 0) m_fill(s, t, hw);
        e_rdata = m_data[s][hw][wi];
      end
      1: begin
        if (hw >= 0 || wa) begin
          if (hw < 0) m_fill(s, t, hw);
          m_data[s][hw][wi] = merge(m_data[s][hw][wi], d, be);
          if (wt) begin ref_mem[a >> 2] = merge(ref_mem[a >> 2], d, be); e_wr++; end
          else m_dirty[s][hw] = 1;
        end else begin
          ref_mem[a >> 2] = merge(ref_mem[a >> 2], d, be); e_wr = 1;
        end
      end
      2: if (hw >= 0) begin m_valid[s][hw] = 0; m_dirty[s][hw] = 0; end
      3: if (hw >= 0 && m_dirty[s][hw]) begin m_wb(s, hw); m_dirty[s][hw] = 0; end
      4: if (hw >= 0) begin
        for (int k = 0; k < WORDS; k++) m_data[s][hw][k] = 0;
        m_dirty[s][hw] = 1;
      end
      default: ;
    endcase
  endtask

  task automatic access(input string req, input int op, input int a, input logic [31:0] d,
                        input logic [3:0] be, input bit c, input bit wt, input bit wa);
    int rd0 = dev_rd, wr0 = dev_wr, guard = 0;
    model(op, a, d, be, c, wt, wa);
    @(negedge clk);
    busy = 1;
    req_valid = 1; req_op = 3'(op); req_addr = ADDR_W'(a); req_wdata = d; req_be = be;
    req_c = c; req_wt = wt; req_wa = wa;
    chk(req_ready == 1'b1, {req, " R14 ready when idle"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && guard < 200) begin @(negedge clk); guard++; end
    chk(rsp_valid == 1'b1, {req, " R14 response"}, 32'(rsp_valid), 32'd1);
    if (op == 0) chk(rsp_rdata == e_rdata, {req, " data"}, rsp_rdata, e_rdata);
    chk(rsp_hit == e_hit, {req, " R3 hit"}, 32'(rsp_hit), 32'(e_hit));
    chk(dev_rd - rd0 == e_rd, {req, " line reads"}, 32'(dev_rd - rd0), 32'(e_rd));
    chk(dev_wr - wr0 == e_wr, {req, " mem writes"}, 32'(dev_wr - wr0), 32'(e_wr));
    @(negedge clk);
    busy = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      dev_mem[i] = 32'(i) * 32'h01010101 ^ 32'hA5000000;
      ref_mem[i] = dev_mem[i];
    end
    for (int s = 0; s < SETS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < WAYS; w++) begin m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0, "R1 no memory request after reset", 32'(mem_req), 32'd0);

    access("R1 R4 first load misses", 0, 'h0100, 0, 0, 1, 0, 0);
    access("R4 repeat load hits", 0, 'h0100, 0, 0, 1, 0, 0);
    access("R3 other word same line", 0, 'h0104, 0, 0, 1, 0, 0);
    access("R8 write-back hit", 1, 'h0104, 32'h1234_5678, 4'b0011, 1, 0, 0);
    access("R8 merged read", 0, 'h0104, 0, 0, 1, 0, 0);
    access("R7 write-through hit", 1, 'h0108, 32'hCAFE_F00D, 4'b1111, 1, 1, 0);
    access("R7 read after wt", 0, 'h0108, 0, 0, 1, 0, 0);
    access("R5 store miss no allocate", 1, 'h0200, 32'hDEAD_BEEF, 4'b0100, 1, 0, 0);
    access("R5 later load misses", 0, 'h0200, 0, 0, 1, 0, 0);
    access("R6 store miss allocate", 1, 'h031C, 32'h0BAD_C0DE, 4'b1001, 1, 0, 1);
    access("R6 merged after fill", 0, 'h031C, 0, 0, 1, 0, 0);
    access("R2 set conflict way2", 0, 'h0140, 0, 0, 1, 0, 0);
    access("R2 set conflict way3", 0, 'h0180, 0, 0, 1, 0, 0);
    access("R9 R8 dirty victim evicted", 0, 'h01C0, 0, 0, 1, 0, 0);
    access("R9 evicted line refetched", 0, 'h0104, 0, 0, 1, 0, 0);
    access("R10 uncached read sees memory", 0, 'h031C, 0, 0, 0, 0, 0);
    access("R10 cached copy intact", 0, 'h031C, 0, 0, 1, 0, 0);
    access("R10 uncached load", 0, 'h0800, 0, 0, 0, 0, 0);
    access("R10 no allocation", 0, 'h0800, 0, 0, 1, 0, 0);
    access("R10 uncached store", 1, 'h0A04, 32'h5555_AAAA, 4'b1111, 0, 0, 0);
    access("R10 uncached store readback", 0, 'h0A04, 0, 0, 0, 0, 0);
    access("R12 clean dirty line", 3, 'h0310, 0, 0, 1, 0, 0);
    access("R12 clean again no traffic", 3, 'h0310, 0, 0, 1, 0, 0);
    access("R12 clean absent line", 3, 'h0E00, 0, 0, 1, 0, 0);
    access("R12 memory holds merged", 0, 'h031C, 0, 0, 0, 0, 0);
    access("R11 dirty store", 1, 'h0354, 32'h7777_7777, 4'b1111, 1, 0, 1);
    access("R11 invalidate", 2, 'h0354, 0, 0, 1, 0, 0);
    access("R11 data discarded", 0, 'h0354, 0, 0, 1, 0, 0);
    access("R11 invalidate absent", 2, 'h0F00, 0, 0, 1, 0, 0);
    access("R13 zero resident", 4, 'h0310, 0, 0, 1, 0, 0);
    access("R13 zeroed word", 0, 'h0314, 0, 0, 1, 0, 0);
    access("R13 zero absent", 4, 'h0900, 0, 0, 1, 0, 0);
    access("R13 absent untouched", 0, 'h0900, 0, 0, 1, 0, 0);
    access("R13 zeroed line dirty", 3, 'h0310, 0, 0, 1, 0, 0);
    access("R13 memory zeroed", 0, 'h0318, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++)
      access("R9 set1 rotation", 0, 'h0050 + i * 'h40, 0, 0, 1, 0, 0);
    for (int i = 0; i < 4; i++)
      access("R6 wt allocate", 1, 'h0460 + i * 'h100, 32'h1000_0001 * (i + 1), 4'b1111, 1, 1, 1);

    begin
      int bad = 0;
      logic [31:0] a0 = 0, e0 = 0;
      for (int i = 0; i < MEMW; i++) begin
        if (dev_mem[i] != ref_mem[i]) begin
          if (bad == 0) begin a0 = dev_mem[i]; e0 = ref_mem[i]; end
          bad++;
        end
      end
      chk(bad == 0, "R8 memory image", a0, e0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule